// File: doc/BRIEF.md
# Top-Priority External Interrupt Delivery Controller

This block sits next to a per-source configuration bank and one hart. Every cycle it receives each source's pending bit, enable bit, edge/level kind and 8-bit priority. From the sources that are both pending and enabled, it picks the most urgent one. It then tests that source against a software threshold and drives a single external-interrupt request line into the hart.

Software reaches the block through the same simple register port as the configuration bank. The port has a valid strobe, a write flag, a word offset and write data, and read data returns combinationally in the cycle of the access. Through this port software sets a domain word (domain-wide enable, with delivery fixed to direct mode), a delivery-enable bit and a threshold. It can read a top-interrupt word, or read a claim word. A claim read returns the same value as the top-interrupt word and also strobes a clear of the winner's pending bit back to the bank.

Top module: `irq_delivery_ctrl`

## Requirements
- R1: After reset, the domain enable, delivery enable and threshold all read zero, and the request line `irq_o` is low.
- R2: The domain word sits at offset 0x0000. Bit 8 is a read/write domain enable. Bits 3:2 are the delivery-mode field: they always read 00, which means direct delivery, whatever is written. Every other bit reads zero.
- R3: The delivery-enable word at 0x1004 keeps only bit 0 as read/write. The threshold word at 0x1006 keeps bits 7:0 as read/write. All other bits of both words read zero.
- R4: A source takes part in selection only when its pending bit and its enable bit are both 1. Its effective priority is its 8-bit priority field, except that a field of 0 counts as 1. The source with the smallest effective priority wins.
- R5: When several candidates share the smallest effective priority, the one with the lowest identity wins. Source index i has identity i+1.
- R6: A threshold of 0 masks nothing. A nonzero threshold T masks every source whose effective priority is greater than or equal to T.
- R7: The top-interrupt word at 0x1007 reports the winner's identity in bits 25:16 and its effective priority in bits 7:0. All other bits are zero. The word reads all zeros when no source qualifies. Writes to this offset change nothing.
- R8: A read at 0x1008 returns the same word as 0x1007. In the same cycle it raises the winner's bit of `clr_pend_o` (bit i for identity i+1), but only when the winner is edge-kind (`src_level_i` bit is 0). A level-kind winner, or no winner, raises no bit.
- R9: `irq_o` is registered. It is 1 in the cycle after an edge at which the domain enable, the delivery enable and a qualifying source are all present, and 0 otherwise.
- R10: `clr_pend_o` stays all-zero for every access other than a claim read, including writes to 0x1008 and reads of 0x1007.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pend_i | input | NSRC | Pending bit per source (index i is identity i+1) |
| src_en_i | input | NSRC | Enable bit per source |
| src_level_i | input | NSRC | 1 = level-kind source, 0 = edge-kind |
| src_prio_i | input | NSRC*8 | Priority field per source, source i in bits 8i+7:8i |
| req_valid_i | input | 1 | Register access strobe |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 13 | Register word offset |
| req_wdata_i | input | 32 | Write data |
| req_rdata_o | output | 32 | Read data, valid in the access cycle |
| clr_pend_o | output | NSRC | One-hot pending-clear strobe produced by a claim read |
| irq_o | output | 1 | External-interrupt request to the hart |

## Verification
The assertions check on every cycle that the winner is a pending, enabled source below any nonzero threshold. They also check that the winner's priority is never zero, that the clear strobe is at most one-hot and appears only during a claim read, that register writes land with the expected masking, and that the request line drops after any cycle without domain enable, delivery enable or a candidate. Only the bench scenarios can show that the right source wins. That covers priority order, identity tie-breaks, the zero-as-one rule and the exact word encodings, and each needs known input patterns with expected identities.

// File: rtl/irqdlv_pkg.sv
package irqdlv_pkg;

  localparam int DATA_W  = 32;
  localparam int PRIO_W  = 8;
  localparam int ID_W    = 10;
  localparam int ADDR_W  = 13;

  localparam int OFF_DOMAIN = 'h0000;
  localparam int OFF_DELIV  = 'h1004;
  localparam int OFF_THRESH = 'h1006;
  localparam int OFF_TOPI   = 'h1007;
  localparam int OFF_CLAIM  = 'h1008;

  localparam int DOM_IE_BIT  = 8;
  localparam int TOPI_ID_LSB = 16;

  typedef logic [PRIO_W-1:0] prio_t;
  typedef logic [ID_W-1:0]   id_t;

  // a stored priority of zero is as urgent as one
  function automatic prio_t eff_prio(input prio_t raw);
    return (raw == '0) ? prio_t'(1) : raw;
  endfunction

  // zero threshold passes all; otherwise strictly below passes
  function automatic logic passes_thresh(input prio_t p, input prio_t thr);
    return (thr == '0) || (p < thr);
  endfunction

  // strict comparison keeps the earlier (lower identity) holder on ties
  function automatic logic displaces(input prio_t cand, input logic held, input prio_t best);
    return !held || (cand < best);
  endfunction

  function automatic logic [DATA_W-1:0] pack_top(input logic vld, input id_t id, input prio_t p);
    logic [DATA_W-1:0] w;
    w = '0;
    if (vld) begin
      w[TOPI_ID_LSB +: ID_W] = id;
      w[PRIO_W-1:0]          = p;
    end
    return w;
  endfunction

endpackage

// File: rtl/irqdlv_select.sv
module irqdlv_select
  import irqdlv_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NSRC-1:0]      pend_i,
  input  logic [NSRC-1:0]      en_i,
  input  logic [NSRC*PRIO_W-1:0] prio_i,
  input  prio_t                thresh_i,
  output logic                 found_o,
  output id_t                  win_id_o,
  output prio_t                win_prio_o,
  output logic [NSRC-1:0]      win_onehot_o
);

  logic  held_c [NSRC+1];
  id_t   id_c   [NSRC+1];
  prio_t pr_c   [NSRC+1];
  logic [NSRC-1:0] cand;
  logic [NSRC-1:0] take;

  assign held_c[0] = 1'b0;
  assign id_c[0]   = '0;
  assign pr_c[0]   = '0;

  for (genvar g = 0; g < NSRC; g++) begin : g_stage
    prio_t ep;
    assign ep        = eff_prio(prio_i[g*PRIO_W +: PRIO_W]);
    assign cand[g]   = pend_i[g] & en_i[g] & passes_thresh(ep, thresh_i);
    assign take[g]   = cand[g] & displaces(ep, held_c[g], pr_c[g]);
    assign held_c[g+1] = held_c[g] | cand[g];
    assign id_c[g+1]   = take[g] ? id_t'(g + 1) : id_c[g];
    assign pr_c[g+1]   = take[g] ? ep : pr_c[g];
    assign win_onehot_o[g] = held_c[NSRC] && (id_c[NSRC] == id_t'(g + 1));
  end

  assign found_o    = held_c[NSRC];
  assign win_id_o   = id_c[NSRC];
  assign win_prio_o = pr_c[NSRC];

  // R4: the winner is a pending and enabled source
  a_r4_winner_live: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> ((pend_i & en_i & win_onehot_o) != '0));
  // R4: reported priority is never zero
  a_r4_prio_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
    found_o |-> (win_prio_o != '0));
  // R6: nonzero threshold bounds the winner
  a_r6_below_thresh: assert property (@(posedge clk) disable iff (!rst_n)
    (found_o && thresh_i != '0) |-> (win_prio_o < thresh_i));
  // R7: no winner means empty identity
  a_r7_empty_id: assert property (@(posedge clk) disable iff (!rst_n)
    !found_o |-> (win_id_o == '0 && win_onehot_o == '0));
  a_r8_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_onehot_o));

endmodule

// File: rtl/irqdlv_regs.sv
module irqdlv_regs
  import irqdlv_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic [DATA_W-1:0] req_rdata_o,
  input  logic              found_i,
  input  id_t               win_id_i,
  input  prio_t             win_prio_i,
  input  logic [NSRC-1:0]   win_onehot_i,
  input  logic [NSRC-1:0]   level_i,
  output logic              dom_ie_o,
  output logic              deliv_en_o,
  output prio_t             thresh_o,
  output logic [NSRC-1:0]   clr_pend_o
);

  logic wr_dom, wr_deliv, wr_thresh, claim_rd;
  logic [DATA_W-1:0] top_word;

  assign wr_dom    = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(OFF_DOMAIN));
  assign wr_deliv  = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(OFF_DELIV));
  assign wr_thresh = req_valid_i && req_write_i && (req_addr_i == ADDR_W'(OFF_THRESH));
  assign claim_rd  = req_valid_i && !req_write_i && (req_addr_i == ADDR_W'(OFF_CLAIM));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dom_ie_o   <= 1'b0;
      deliv_en_o <= 1'b0;
      thresh_o   <= '0;
    end else begin
      if (wr_dom)    dom_ie_o   <= req_wdata_i[DOM_IE_BIT];
      if (wr_deliv)  deliv_en_o <= req_wdata_i[0];
      if (wr_thresh) thresh_o   <= req_wdata_i[PRIO_W-1:0];
    end
  end

  assign top_word = pack_top(found_i, win_id_i, win_prio_i);

  always_comb begin
    req_rdata_o = '0;
    if (req_valid_i && !req_write_i) begin
      case (req_addr_i)
        ADDR_W'(OFF_DOMAIN): req_rdata_o[DOM_IE_BIT] = dom_ie_o;
        ADDR_W'(OFF_DELIV):  req_rdata_o[0]          = deliv_en_o;
        ADDR_W'(OFF_THRESH): req_rdata_o[PRIO_W-1:0] = thresh_o;
        ADDR_W'(OFF_TOPI),
        ADDR_W'(OFF_CLAIM):  req_rdata_o             = top_word;
        default:             req_rdata_o             = '0;
      endcase
    end
  end

  assign clr_pend_o = (claim_rd && found_i) ? (win_onehot_i & ~level_i) : '0;

  // R8/R10: clears appear only inside a claim read
  a_r10_clear_needs_claim: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_pend_o != '0) |-> (req_valid_i && !req_write_i && req_addr_i == ADDR_W'(OFF_CLAIM)));
  // R8: level-kind sources are never cleared
  a_r8_level_kept: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_pend_o & level_i) == '0));
  // R3: threshold write lands on the next cycle
  a_r3_thresh_write: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid_i && req_write_i && req_addr_i == ADDR_W'(OFF_THRESH))
      |=> (thresh_o == $past(req_wdata_i[PRIO_W-1:0])));
  // R2: domain enable holds without a domain write
  a_r2_dom_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid_i && req_write_i && req_addr_i == ADDR_W'(OFF_DOMAIN)) |=> $stable(dom_ie_o));

endmodule

// File: rtl/irq_delivery_ctrl.sv
module irq_delivery_ctrl
  import irqdlv_pkg::*;
#(
  parameter int NSRC = 32
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NSRC-1:0]          src_pend_i,
  input  logic [NSRC-1:0]          src_en_i,
  input  logic [NSRC-1:0]          src_level_i,
  input  logic [NSRC*8-1:0]        src_prio_i,
  input  logic                     req_valid_i,
  input  logic                     req_write_i,
  input  logic [12:0]              req_addr_i,
  input  logic [31:0]              req_wdata_i,
  output logic [31:0]              req_rdata_o,
  output logic [NSRC-1:0]          clr_pend_o,
  output logic                     irq_o
);

  logic            found;
  id_t             win_id;
  prio_t           win_prio;
  logic [NSRC-1:0] win_onehot;
  logic            dom_ie, deliv_en;
  prio_t           thresh;
  logic            irq_next;

  irqdlv_select #(.NSRC(NSRC)) u_select (
    .clk          (clk),
    .rst_n        (rst_n),
    .pend_i       (src_pend_i),
    .en_i         (src_en_i),
    .prio_i       (src_prio_i),
    .thresh_i     (thresh),
    .found_o      (found),
    .win_id_o     (win_id),
    .win_prio_o   (win_prio),
    .win_onehot_o (win_onehot)
  );

  irqdlv_regs #(.NSRC(NSRC)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_valid_i  (req_valid_i),
    .req_write_i  (req_write_i),
    .req_addr_i   (req_addr_i),
    .req_wdata_i  (req_wdata_i),
    .req_rdata_o  (req_rdata_o),
    .found_i      (found),
    .win_id_i     (win_id),
    .win_prio_i   (win_prio),
    .win_onehot_i (win_onehot),
    .level_i      (src_level_i),
    .dom_ie_o     (dom_ie),
    .deliv_en_o   (deliv_en),
    .thresh_o     (thresh),
    .clr_pend_o   (clr_pend_o)
  );

  assign irq_next = dom_ie & deliv_en & found;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_o <= 1'b0;
    else        irq_o <= irq_next;
  end

  // R9: any missing condition drops the request next cycle
  a_r9_dom_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !dom_ie |=> !irq_o);
  a_r9_deliv_gate: assert property (@(posedge clk) disable iff (!rst_n)
    !deliv_en |=> !irq_o);
  a_r9_need_source: assert property (@(posedge clk) disable iff (!rst_n)
    !found |=> !irq_o);

endmodule

// File: tb/test_irq_delivery_ctrl.sv
module test_irq_delivery_ctrl;

  localparam int NSRC = 32;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [NSRC-1:0]   pend = '0, en = '0, lvl = '0;
  logic [NSRC*8-1:0] prio = '0;
  logic              vld = 1'b0, wr = 1'b0;
  logic [12:0]       addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [NSRC-1:0]   clr;
  logic              irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #5 clk = ~clk;

  irq_delivery_ctrl #(.NSRC(NSRC)) i_irq_delivery_ctrl (
    .clk(clk), .rst_n(rst_n), .src_pend_i(pend), .src_en_i(en),
    .src_level_i(lvl), .src_prio_i(prio), .req_valid_i(vld),
    .req_write_i(wr), .req_addr_i(addr), .req_wdata_i(wdata),
    .req_rdata_o(rdata), .clr_pend_o(clr), .irq_o(irq)
  );

  typedef struct packed {
    logic [31:0] pend;
    logic [31:0] en;
    logic [1:0]  mode;
    logic [7:0]  thr;
    logic [9:0]  id;
    logic [7:0]  pr;
  } vec_t;

  // mode 0: all 5; mode 1: 40-i; mode 2: all 0; mode 3: i
  localparam vec_t TABLE [14] = '{
    '{32'h0000_0000, 32'hFFFF_FFFF, 2'd0, 8'd0,  10'd0,  8'd0},  // R7 empty
    '{32'h0000_0010, 32'hFFFF_FFFF, 2'd0, 8'd0,  10'd5,  8'd5},  // R4 single
    '{32'h0000_0030, 32'h0000_0020, 2'd0, 8'd0,  10'd6,  8'd5},  // R4 enable gate
    '{32'hF000_0001, 32'hFFFF_FFFF, 2'd0, 8'd0,  10'd1,  8'd5},  // R5 tie
    '{32'h0000_0101, 32'hFFFF_FFFF, 2'd1, 8'd0,  10'd9,  8'd32}, // R4 order
    '{32'h8000_0001, 32'hFFFF_FFFF, 2'd1, 8'd0,  10'd32, 8'd9},  // R4 top index
    '{32'h8000_0001, 32'hFFFF_FFFF, 2'd1, 8'd9,  10'd0,  8'd0},  // R6 equal masked
    '{32'h8000_0001, 32'hFFFF_FFFF, 2'd1, 8'd10, 10'd32, 8'd9},  // R6 below passes
    '{32'h0000_000C, 32'hFFFF_FFFF, 2'd2, 8'd0,  10'd3,  8'd1},  // R4 zero as one
    '{32'h0000_0003, 32'hFFFF_FFFF, 2'd3, 8'd0,  10'd1,  8'd1},  // R5 0 vs 1 tie
    '{32'h0000_0006, 32'hFFFF_FFFF, 2'd3, 8'd0,  10'd2,  8'd1},  // R4 1 beats 2
    '{32'h0000_0003, 32'hFFFF_FFFF, 2'd3, 8'd1,  10'd0,  8'd0},  // R6 thr one
    '{32'h0000_0006, 32'hFFFF_FFFF, 2'd3, 8'd2,  10'd2,  8'd1},  // R6 thr two
    '{32'hFFFF_FFFF, 32'h0000_0000, 2'd0, 8'd0,  10'd0,  8'd0}   // R4 none enabled
  };

  function automatic logic [NSRC*8-1:0] prio_of(input logic [1:0] m);
    logic [NSRC*8-1:0] v;
    for (int i = 0; i < NSRC; i++) begin
      case (m)
        2'd0: v[i*8 +: 8] = 8'd5;
        2'd1: v[i*8 +: 8] = 8'(40 - i);
        2'd2: v[i*8 +: 8] = 8'd0;
        default: v[i*8 +: 8] = 8'(i);
      endcase
    end
    return v;
  endfunction

  function automatic logic [31:0] top_of(input logic [9:0] id, input logic [7:0] p);
    return {6'd0, id, 8'd0, p};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [12:0] a, input logic [31:0] d);
    @(negedge clk);
    vld = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    vld = 1'b0; wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [12:0] a, output logic [31:0] d, output logic [NSRC-1:0] c);
    @(negedge clk);
    vld = 1'b1; wr = 1'b0; addr = a;
    #1;
    d = rdata; c = clr;
    vld = 1'b0;
  endtask

  task automatic settle_edges(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
    #1;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic [NSRC-1:0] c;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(13'h0000, d, c); chk("R1 domain", d, 32'h0);
    rd_reg(13'h1004, d, c); chk("R1 deliv", d, 32'h0);
    rd_reg(13'h1006, d, c); chk("R1 thresh", d, 32'h0);
    chk("R1 irq", {31'd0, irq}, 32'h0);

    // R2 domain word
    wr_reg(13'h0000, 32'hFFFF_FFFF);
    rd_reg(13'h0000, d, c); chk("R2 domain all ones", d, 32'h0000_0100);
    wr_reg(13'h0000, 32'h0000_000C);
    rd_reg(13'h0000, d, c); chk("R2 mode fixed", d, 32'h0);

    // R3 delivery and threshold
    wr_reg(13'h1004, 32'hFFFF_FFFF);
    rd_reg(13'h1004, d, c); chk("R3 deliv", d, 32'h1);
    wr_reg(13'h1006, 32'h0000_01FF);
    rd_reg(13'h1006, d, c); chk("R3 thresh", d, 32'hFF);
    wr_reg(13'h1004, 32'h0);

    // R4 R5 R6 R7 table
    for (int v = 0; v < 14; v++) begin
      pend = TABLE[v].pend; en = TABLE[v].en; prio = prio_of(TABLE[v].mode);
      wr_reg(13'h1006, {24'd0, TABLE[v].thr});
      rd_reg(13'h1007, d, c);
      chk($sformatf("R4/R5/R6/R7 vector %0d", v), d, top_of(TABLE[v].id, TABLE[v].pr));
    end

    // R7 writes to top word ignored
    wr_reg(13'h1006, 32'h0);
    pend = 32'h10; en = '1; prio = prio_of(2'd0); lvl = '0;
    wr_reg(13'h1007, 32'hFFFF_FFFF);
    rd_reg(13'h1007, d, c); chk("R7 write ignored", d, top_of(10'd5, 8'd5));
    rd_reg(13'h1006, d, c); chk("R7 thresh untouched", d, 32'h0);

    // R9 request line
    wr_reg(13'h0000, 32'h100);
    wr_reg(13'h1004, 32'h1);
    settle_edges(1); chk("R9 irq on", {31'd0, irq}, 32'h1);
    wr_reg(13'h1004, 32'h0);
    settle_edges(1); chk("R9 deliv off", {31'd0, irq}, 32'h0);
    wr_reg(13'h1004, 32'h1);
    wr_reg(13'h0000, 32'h0);
    settle_edges(1); chk("R9 domain off", {31'd0, irq}, 32'h0);
    wr_reg(13'h0000, 32'h100);
    wr_reg(13'h1006, 32'h5);
    settle_edges(1); chk("R9 R6 masked", {31'd0, irq}, 32'h0);
    wr_reg(13'h1006, 32'h0);
    settle_edges(1); chk("R9 unmasked", {31'd0, irq}, 32'h1);

    // R8 claim
    rd_reg(13'h1008, d, c);
    chk("R8 claim data", d, top_of(10'd5, 8'd5));
    chk("R8 edge clear", c, 32'h0000_0010);
    lvl = 32'h10;
    rd_reg(13'h1008, d, c);
    chk("R8 level data", d, top_of(10'd5, 8'd5));
    chk("R8 level kept", c, 32'h0);
    lvl = '0;
    pend = '0;
    rd_reg(13'h1008, d, c);
    chk("R8 empty data", d, 32'h0);
    chk("R8 empty clear", c, 32'h0);

    // R10 no clear outside claim reads
    pend = 32'h10;
    rd_reg(13'h1007, d, c); chk("R10 top read", c, 32'h0);
    @(negedge clk);
    vld = 1'b1; wr = 1'b1; addr = 13'h1008; wdata = 32'hFFFF_FFFF;
    #1; c = clr;
    @(negedge clk); vld = 1'b0; wr = 1'b0;
    chk("R10 claim write", c, 32'h0);

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule